// File: doc/BRIEF.md
# Low-Power Wake Source Controller

This block watches a set of external pins and a countdown timer while the system is asleep, and records which source brought it back. Five pin sources are handled: three general-purpose pins, a pushbutton and a serial receive line. One general pin and the receive line wake on a rising edge. The other two general pins and the pushbutton wake on a high level. Every pin first passes through a synchroniser. Each general pin also has a qualifier that says whether it is configured as a digital input.

A small register interface carries the per-source enables, a timer arm bit, the timer reload value and a sticky flag word. Flags are cleared by writing 1 to them. The timer is armed by a register write. It counts down only while the processor requests sleep or display-only mode. When it reaches zero it raises its own flag and disarms itself. A reset-cause flag records an external reset request. Whenever a source flag goes from clear to set during a low-power mode, the power manager receives a single-cycle wake pulse.

Top module: `wake_src_ctrl`

## Requirements
- R1: After reset, the control word (address 0), the flag word (address 2) and the timer count (address 3) all read 0, and `wake_pulse` is low.
- R2: Source 0 (`pin_gp_a`, control/flag bit 0) is edge triggered. A rising edge sets flag bit 0, and the flag stays set after the pin falls. While the pin stays high, a write-1 clear succeeds.
- R3: Sources 1, 2 and 3 (`pin_gp_b`, `pin_gp_c`, `pin_button`, bits 1 to 3) are level triggered. The flag sets while the pin is high, and a write-1 clear has no effect while the pin is still high.
- R4: Enable bits 0 to 2 act only when the matching `gp_is_input` bit is 1. The pushbutton (bit 3) and the receive pin (bit 4) need no qualifier.
- R5: A pin flag (bits 0 to 4) reads 0 in the cycle after its effective enable is low, even if it was set before.
- R6: Source 4 (`pin_rx`, bit 4) sets flag bit 4 on a rising edge.
- R7: A write to address 0 with bit 5 set loads the timer from the reload register (address 1) and arms it. The arm state reads back as control bit 5. A write with bit 5 clear disarms the timer.
- R8: The armed timer decrements by one on each `tick` only while `sleep_req` or `display_req` is high. Otherwise the count holds.
- R9: When an armed, running timer is at 0, flag bit 5 sets, the arm bit clears and the count stays 0.
- R10: `wake_pulse` is high for exactly one cycle when a flag in bits 0 to 5 changes from 0 to 1 while `sleep_req` or `display_req` was high. It stays low when neither is high.
- R11: Writing 1 to a flag bit (address 2) clears it when its source is inactive. Writing 0 leaves it unchanged.
- R12: `ext_rst_req` sets flag bit 6 (reset cause). This flag never produces a wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 reload, 2 flags (write-1 clear) |
| wr_data | input | TMR_W | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 reload, 2 flags, 3 count |
| rd_data | output | TMR_W | Combinational read data |
| pin_gp_a | input | 1 | General pin, rising-edge wake |
| pin_gp_b | input | 1 | General pin, high-level wake |
| pin_gp_c | input | 1 | General pin, high-level wake |
| pin_button | input | 1 | Pushbutton, high-level wake |
| pin_rx | input | 1 | Serial receive, rising-edge wake |
| gp_is_input | input | 3 | Digital-input qualifiers for pins a, b, c |
| sleep_req | input | 1 | Processor sleep mode request |
| display_req | input | 1 | Processor display-only mode request |
| tick | input | 1 | Timer decrement enable |
| ext_rst_req | input | 1 | External reset request event |
| wake_pulse | output | 1 | Single-cycle wake to the power manager |

## Verification
The bench builds the block with an 8-bit timer and a three-stage synchroniser. The narrow timer keeps reload values and expiry within a few dozen cycles. The deeper chain checks that flag timing follows the stage parameter and does not rely on a fixed latency. The small reload values also make the hold-then-count behaviour of R8 visible count by count.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int NSRC    = 5;
  localparam int NGP     = 3;
  localparam int NFLAG   = 7;
  localparam int FLG_TMR = 5;
  localparam int FLG_RST = 6;
  localparam int CTL_ARM = 5;

  localparam logic [1:0] A_CTRL   = 2'd0;
  localparam logic [1:0] A_RELOAD = 2'd1;
  localparam logic [1:0] A_FLAGS  = 2'd2;
  localparam logic [1:0] A_COUNT  = 2'd3;

  // 1 marks an edge-triggered source, 0 a level-triggered one
  localparam logic [NSRC-1:0] EDGE_SRC = 5'b10001;

  function automatic logic src_event(input logic is_edge, input logic lvl, input logic rise);
    return is_edge ? rise : lvl;
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= pin_in;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = stg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm_load,
  input  logic         disarm,
  input  logic [W-1:0] reload,
  input  logic         run,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         armed,
  output logic         fire
);
  function automatic logic [W-1:0] step_down(input logic [W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  assign fire = armed && run && (count == '0) && !arm_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else if (arm_load) begin
      count <= reload;
      armed <= 1'b1;
    end else if (disarm || fire) begin
      armed <= 1'b0;
    end else if (armed && run && tick) begin
      count <= step_down(count);
    end
  end
endmodule

// File: rtl/wake_flags.sv
module wake_flags
  import wake_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  lvl,
  input  logic [NSRC-1:0]  rise,
  input  logic [NSRC-1:0]  eff_en,
  input  logic             tmr_fire,
  input  logic             ext_rst_req,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic             lowpower,
  output logic [NFLAG-1:0] flags_q,
  output logic [NFLAG-1:0] new_set,
  output logic             wake_pulse
);
  logic [NSRC-1:0]  src_hit;
  logic [NFLAG-1:0] set_cond;
  logic [NFLAG-1:0] flags_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign src_hit[i] = eff_en[i] & src_event(EDGE_SRC[i], lvl[i], rise[i]);
  end

  assign set_cond = {ext_rst_req, tmr_fire, src_hit};
  assign new_set  = set_cond & ~flags_q;

  always_comb begin
    for (int i = 0; i < NFLAG; i++) begin
      if (i < NSRC && !eff_en[i]) flags_d[i] = 1'b0;
      else flags_d[i] = set_cond[i] | (flags_q[i] & ~clr_mask[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q    <= '0;
      wake_pulse <= 1'b0;
    end else begin
      flags_q    <= flags_d;
      wake_pulse <= lowpower && (|new_set[FLG_TMR:0]);
    end
  end
endmodule

// File: rtl/wake_src_ctrl.sv
module wake_src_ctrl
  import wake_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [TMR_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [TMR_W-1:0] rd_data,
  input  logic             pin_gp_a,
  input  logic             pin_gp_b,
  input  logic             pin_gp_c,
  input  logic             pin_button,
  input  logic             pin_rx,
  input  logic [NGP-1:0]   gp_is_input,
  input  logic             sleep_req,
  input  logic             display_req,
  input  logic             tick,
  input  logic             ext_rst_req,
  output logic             wake_pulse
);
  logic [NSRC-1:0]  ctrl_en;
  logic [TMR_W-1:0] reload_q;
  logic [NSRC-1:0]  pins, lvl, rise, eff_en;
  logic [NFLAG-1:0] flags_q, new_set, clr_mask;
  logic [TMR_W-1:0] count;
  logic             armed, tmr_fire, arm_load, disarm, lowpower, wr_ctrl;

  assign pins     = {pin_rx, pin_button, pin_gp_c, pin_gp_b, pin_gp_a};
  assign eff_en   = ctrl_en & {{(NSRC-NGP){1'b1}}, gp_is_input};
  assign lowpower = sleep_req | display_req;
  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign arm_load = wr_ctrl && wr_data[CTL_ARM];
  assign disarm   = wr_ctrl && !wr_data[CTL_ARM];
  assign clr_mask = (wr_en && wr_addr == A_FLAGS) ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL)   ctrl_en  <= wr_data[NSRC-1:0];
      if (wr_addr == A_RELOAD) reload_q <= wr_data;
    end
  end

  wake_sync #(.N(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .lvl(lvl), .rise(rise)
  );

  wake_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .arm_load(arm_load), .disarm(disarm),
    .reload(reload_q), .run(lowpower), .tick(tick),
    .count(count), .armed(armed), .fire(tmr_fire)
  );

  wake_flags u_flags (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .eff_en(eff_en),
    .tmr_fire(tmr_fire), .ext_rst_req(ext_rst_req), .clr_mask(clr_mask),
    .lowpower(lowpower), .flags_q(flags_q), .new_set(new_set),
    .wake_pulse(wake_pulse)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL:   rd_data[CTL_ARM:0]   = {armed, ctrl_en};
      A_RELOAD: rd_data              = reload_q;
      A_FLAGS:  rd_data[NFLAG-1:0]   = flags_q;
      default:  rd_data              = count;
    endcase
  end
endmodule

// File: rtl/wake_src_ctrl_chk.sv
module wake_src_ctrl_chk
  import wake_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wake_pulse,
  input logic             sleep_req,
  input logic             display_req,
  input logic             tick,
  input logic             ext_rst_req,
  input logic [NFLAG-1:0] flags_q,
  input logic [NSRC-1:0]  eff_en,
  input logic             armed,
  input logic             arm_load,
  input logic             tmr_fire,
  input logic [TMR_W-1:0] count
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R10
  AST_PULSE_LOWPOWER: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(sleep_req || display_req)); // R10
  AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q[NSRC-1:0] & ~$past(eff_en)) == '0)); // R5
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_load && !(armed && (sleep_req || display_req) && tick)) |=> $stable(count)); // R8
  AST_FIRE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_fire && !arm_load) |=> (!armed && flags_q[FLG_TMR] && count == '0)); // R9
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_req |=> flags_q[FLG_RST]); // R12
endmodule

bind wake_src_ctrl wake_src_ctrl_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wake_pulse(wake_pulse), .sleep_req(sleep_req),
  .display_req(display_req), .tick(tick), .ext_rst_req(ext_rst_req),
  .flags_q(flags_q), .eff_en(eff_en), .armed(armed), .arm_load(arm_load),
  .tmr_fire(tmr_fire), .count(count)
);

// File: tb/tb_wake_src_ctrl.sv
module tb_wake_src_ctrl;
  localparam int TW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0; logic [1:0] wr_addr = 0; logic [TW-1:0] wr_data = 0;
  logic [1:0] rd_addr = 0; logic [TW-1:0] rd_data;
  logic pa = 0, pb = 0, pc = 0, pbtn = 0, prx = 0;
  logic [2:0] gpin = 0;
  logic sleep = 0, disp = 0, tick = 0, xrst = 0;
  logic wake;
  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wake_src_ctrl #(.TMR_W(TW), .SYNC_STAGES(3)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_gp_a(pa), .pin_gp_b(pb),
    .pin_gp_c(pc), .pin_button(pbtn), .pin_rx(prx), .gp_is_input(gpin),
    .sleep_req(sleep), .display_req(disp), .tick(tick), .ext_rst_req(xrst),
    .wake_pulse(wake)
  );

  always @(negedge clk) if (rst_n && wake) pulses++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = TW'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic t_reset;
    int v;
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(2, v); chk("R1 flags", v, 0);
    rd(3, v); chk("R1 count", v, 0);
    chk("R1 wake", int'(wake), 0);
  endtask

  task automatic t_edge_a;
    int v, p0;
    gpin = 3'b111; sleep = 1; wr(0, 6'h01); p0 = pulses;
    pa = 1; cyc(8);
    rd(2, v); chk("R2 flag0 set", v, 1);
    chk("R10 one pulse", pulses - p0, 1);
    wr(2, 0); rd(2, v); chk("R11 write0 keeps", v, 1);
    wr(2, 1); cyc(1); rd(2, v); chk("R2 clear while high", v, 0);
    pa = 0; cyc(6); pa = 1; cyc(8);
    rd(2, v); chk("R2 re-edge", v, 1);
    pa = 0; cyc(6); rd(2, v); chk("R2 sticky after fall", v, 1);
    wr(2, 1); rd(2, v); chk("R11 cleared", v, 0);
    sleep = 0; wr(0, 0);
  endtask

  task automatic t_level;
    int v, p0;
    gpin = 3'b111; sleep = 1; wr(0, 6'h06); p0 = pulses;
    pb = 1; cyc(8);
    rd(2, v); chk("R3 flag1 set", v, 2);
    wr(2, 2); cyc(2); rd(2, v); chk("R3 clear blocked", v, 2);
    chk("R10 no repeat pulse", pulses - p0, 1);
    pb = 0; pc = 1; cyc(8);
    rd(2, v); chk("R3 flag2 set", v, 6);
    pc = 0; cyc(6); wr(2, 6); rd(2, v); chk("R11 level clear", v, 0);
    gpin = 3'b000; pb = 1; cyc(8);
    rd(2, v); chk("R4 no qualifier", v, 0);
    pb = 0; wr(0, 6'h08); pbtn = 1; cyc(8);
    rd(2, v); chk("R4 button unqualified", v, 8);
    wr(0, 0); cyc(1); rd(2, v); chk("R5 disabled clears", v, 0);
    pbtn = 0; sleep = 0; gpin = 3'b111; cyc(6);
  endtask

  task automatic t_rx;
    int v, p0;
    wr(0, 6'h10); p0 = pulses;
    prx = 1; cyc(8);
    rd(2, v); chk("R6 rx flag", v, 16);
    chk("R10 no pulse awake", pulses - p0, 0);
    prx = 0; cyc(6); wr(2, 16); rd(2, v); chk("R11 rx clear", v, 0);
    wr(0, 0);
  endtask

  task automatic t_timer;
    int v, p0;
    wr(1, 5); wr(0, 6'h20);
    rd(3, v); chk("R7 loaded", v, 5);
    rd(0, v); chk("R7 armed", v, 32);
    tick = 1; cyc(6); rd(3, v); chk("R8 hold awake", v, 5);
    tick = 0; disp = 1; cyc(4); rd(3, v); chk("R8 hold no tick", v, 5);
    p0 = pulses;
    tick = 1; cyc(2); tick = 0; cyc(1);
    rd(3, v); chk("R8 two ticks", v, 3);
    tick = 1; cyc(10); tick = 0;
    rd(2, v); chk("R9 timer flag", v, 32);
    rd(3, v); chk("R9 count zero", v, 0);
    rd(0, v); chk("R9 disarmed", v, 0);
    chk("R10 timer pulse", pulses - p0, 1);
    disp = 0; wr(2, 32); rd(2, v); chk("R11 timer clear", v, 0);
    wr(1, 7); wr(0, 6'h20); wr(0, 0);
    rd(0, v); chk("R7 disarm write", v, 0);
  endtask

  task automatic t_rst_cause;
    int v, p0;
    sleep = 1; p0 = pulses;
    @(negedge clk); xrst = 1; @(negedge clk); xrst = 0; cyc(2);
    rd(2, v); chk("R12 cause flag", v, 64);
    chk("R12 no pulse", pulses - p0, 0);
    wr(2, 64); rd(2, v); chk("R11 cause clear", v, 0);
    sleep = 0;
  endtask

  initial begin
    cyc(3); t_reset(); rst_n = 1; cyc(2); t_reset();
    t_edge_a(); t_level(); t_rx(); t_timer(); t_rst_cause();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule